// File: doc/BRIEF.md
# Quad Wiper Serial Command Controller

This block is a two-wire serial slave that owns four 8-bit wiper position registers. Each wiper has a bank of four 8-bit storage registers. SCL and SDA are oversampled on the system clock. The controller finds START and STOP conditions and checks an identifier byte. It then decodes an instruction byte and runs one of three kinds of sequence:

- a two-byte transfer between a wiper and one of its storage registers, either for one channel or ganged across all four;
- a three-byte read or write of a single register;
- a streaming step mode, in which each SCL pulse moves the selected wiper by one position.

All four wiper positions are presented in parallel on one bus. The storage registers stand in for non-volatile cells. Any operation that changes them, or loads a wiper from them, holds a busy flag for `WR_DELAY` system clock cycles and only completes when that window ends. While the flag is set, the controller refuses to acknowledge a new identifier byte.

Top module: `quad_wiper_ctrl`

## Requirements
- R1: The identifier byte is acknowledged only when its upper nibble is 0101 and its lower nibble equals `dev_addr`. Any other identifier gets no acknowledge, and the rest of that transaction has no effect.
- R2: The instruction byte is laid out as opcode in bits 7:4, storage select in bits 3:2 and wiper select in bits 1:0. Accepted opcodes are:
  - 1001: read wiper
  - 1010: write wiper
  - 1011: read storage
  - 1100: write storage
  - 1101: storage to wiper
  - 1110: wiper to storage
  - 0001: ganged storage to wiper
  - 1000: ganged wiper to storage
  - 0010: step mode

  An accepted opcode is acknowledged. Any other opcode gets no acknowledge and causes no change.
- R3: In a read, the controller drives the selected register onto SDA MSB first. Each bit changes after a falling SCL edge.
- R4: In a write-wiper instruction, the data byte is acknowledged. The wiper output takes the new value at the falling edge that ends that acknowledge, with no busy period.
- R5: A write-storage instruction raises `nv_busy` for exactly `WR_DELAY` cycles. The storage register holds the new value once `nv_busy` falls.
- R6: A storage-to-wiper transfer leaves the wiper output unchanged while `nv_busy` is high. The new value appears in the cycle in which `nv_busy` falls.
- R7: A wiper-to-storage transfer copies the selected wiper into its selected storage register when the busy period ends.
- R8: The ganged forms apply the same storage select to all four channels at once and ignore the wiper select.
- R9: In step mode, the SDA level sampled at each SCL rising edge chooses the direction: high steps up, low steps down. The step of one is applied at the following falling edge. The SCL pulse inside a STOP produces no step.
- R10: Stepping saturates at 8'hFF and 8'h00 and never wraps.
- R11: While `nv_busy` is high, an identifier byte is not acknowledged even if it matches.
- R12: After reset, all wipers read 0 and `nv_busy` and `sda_pull` are low. A START aborts any sequence in progress without effect, and a STOP releases SDA.
- R13: `sda_pull` rises only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| dev_addr | input | 4 | Strapped device address |
| sda_pull | output | 1 | High to pull SDA low (open drain) |
| nv_busy | output | 1 | Storage or delayed-transfer operation in progress |
| wiper_pos | output | 32 | Wiper positions, wiper n in bits 8n+7:8n |

## Verification
Some properties are checked on every cycle:
- the open-drain pull only rises while SCL is low;
- SDA is released after STOP;
- each busy window lasts exactly `WR_DELAY` cycles;
- the wiper bus never moves inside a busy window.

The bench's scenarios are what show the rest:
- identifier and opcode rejection;
- data ordering on reads;
- the exact values moved by single and ganged transfers;
- the direction and saturation of stepping, including no step from the STOP pulse;
- the abort by a repeated START.

// File: rtl/quad_wiper_ctrl.sv
`timescale 1ns/1ps
module quad_wiper_ctrl #(
  parameter int          WR_DELAY = 64,
  parameter logic [3:0]  ID_CODE  = 4'b0101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [3:0]  dev_addr,
  output logic        sda_pull,
  output logic        nv_busy,
  output logic [31:0] wiper_pos
);
  localparam int CW = $clog2(WR_DELAY + 1);

  localparam logic [3:0] OP_RD_W  = 4'b1001, OP_WR_W  = 4'b1010,
                         OP_RD_S  = 4'b1011, OP_WR_S  = 4'b1100,
                         OP_S2W   = 4'b1101, OP_W2S   = 4'b1110,
                         OP_GS2W  = 4'b0001, OP_GW2S  = 4'b1000,
                         OP_STEP  = 4'b0010;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INSTR, S_DATA, S_STEP, S_SKIP} st_t;
  typedef enum logic [1:0] {P_NONE, P_TOW, P_TOS, P_WRS} pk_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q, scl_s, sda_s;
  logic       start_p, stop_p, rise, fall;

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, instr;
  logic       ack_drv, rd_on, step_up;
  logic [7:0] wcr [4];
  logic [7:0] sto [16];
  logic [CW-1:0] bcnt;
  pk_t        pk;
  logic [3:0] pmask;
  logic [1:0] psel;
  logic [7:0] pdata;

  assign scl_s   = scl_sy[1];
  assign sda_s   = sda_sy[1];
  assign start_p = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;

  assign sda_pull  = ack_drv | (rd_on & ~tx[7]);
  assign nv_busy   = bcnt != '0;
  assign wiper_pos = {wcr[3], wcr[2], wcr[1], wcr[0]};

  wire [3:0] op   = instr[7:4];
  wire [1:0] rsel = instr[3:2];
  wire [1:0] wsel = instr[1:0];

  function automatic logic op_ok(input logic [3:0] o);
    return o inside {OP_RD_W, OP_WR_W, OP_RD_S, OP_WR_S, OP_S2W, OP_W2S,
                     OP_GS2W, OP_GW2S, OP_STEP};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;              sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; instr <= '0;
      ack_drv <= 1'b0; rd_on <= 1'b0; step_up <= 1'b0;
      bcnt <= '0; pk <= P_NONE; pmask <= '0; psel <= '0; pdata <= '0;
      for (int i = 0; i < 4; i++)  wcr[i] <= '0;
      for (int i = 0; i < 16; i++) sto[i] <= '0;
    end else begin
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (bcnt == CW'(1)) begin
        for (int i = 0; i < 4; i++)
          if (pmask[i])
            case (pk)
              P_TOW:   wcr[i] <= sto[{2'(i), psel}];
              P_TOS:   sto[{2'(i), psel}] <= wcr[i];
              P_WRS:   sto[{2'(i), psel}] <= pdata;
              default: ;
            endcase
        pk <= P_NONE;
      end

      if (start_p) begin
        st <= S_ADDR; cnt <= '0; ack_drv <= 1'b0; rd_on <= 1'b0;
      end else if (stop_p) begin
        st <= S_IDLE; cnt <= '0; ack_drv <= 1'b0; rd_on <= 1'b0;
      end else if (rise) begin
        if (st inside {S_ADDR, S_INSTR, S_DATA}) begin
          if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (st == S_STEP) step_up <= sda_s;
      end else if (fall) begin
        if (st == S_STEP) begin
          if (step_up) wcr[wsel] <= (wcr[wsel] == 8'hFF) ? 8'hFF : wcr[wsel] + 8'd1;
          else         wcr[wsel] <= (wcr[wsel] == 8'h00) ? 8'h00 : wcr[wsel] - 8'd1;
        end else if (st inside {S_ADDR, S_INSTR, S_DATA}) begin
          if (rd_on && cnt >= 4'd1 && cnt <= 4'd7) tx <= {tx[6:0], 1'b0};
          if (cnt == 4'd8) begin
            case (st)
              S_ADDR:  if (sh == {ID_CODE, dev_addr} && !nv_busy) ack_drv <= 1'b1;
                       else st <= S_SKIP;
              S_INSTR: if (op_ok(sh[7:4])) begin ack_drv <= 1'b1; instr <= sh; end
                       else st <= S_SKIP;
              default: if (op == OP_RD_W || op == OP_RD_S) rd_on <= 1'b0;
                       else ack_drv <= 1'b1;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0; ack_drv <= 1'b0;
            case (st)
              S_ADDR: st <= S_INSTR;
              S_INSTR: begin
                st <= S_SKIP;
                case (op)
                  OP_RD_W: begin st <= S_DATA; rd_on <= 1'b1; tx <= wcr[wsel]; end
                  OP_RD_S: begin st <= S_DATA; rd_on <= 1'b1; tx <= sto[{wsel, rsel}]; end
                  OP_WR_W, OP_WR_S: st <= S_DATA;
                  OP_STEP: st <= S_STEP;
                  OP_S2W, OP_W2S, OP_GS2W, OP_GW2S: begin
                    pk    <= (op == OP_S2W || op == OP_GS2W) ? P_TOW : P_TOS;
                    pmask <= (op == OP_GS2W || op == OP_GW2S) ? 4'hF : 4'(1 << wsel);
                    psel  <= rsel;
                    bcnt  <= CW'(WR_DELAY);
                  end
                  default: ;
                endcase
              end
              default: begin
                st <= S_SKIP;
                if (op == OP_WR_W) wcr[wsel] <= sh;
                else if (op == OP_WR_S) begin
                  pk <= P_WRS; pmask <= 4'(1 << wsel); psel <= rsel; pdata <= sh;
                  bcnt <= CW'(WR_DELAY);
                end
              end
            endcase
          end
        end
      end
    end
  end
endmodule

module qwc_checker #(parameter int WR_DELAY = 64) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        stop_p,
  input logic        sda_pull,
  input logic        nv_busy,
  input logic [31:0] wiper_pos
);
  int busy_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       busy_len <= 0;
    else if (nv_busy) busy_len <= busy_len + 1;
    else              busy_len <= 0;

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);  // R13
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_pull);  // R12
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_busy) |-> busy_len == WR_DELAY);  // R5
  AST_WIPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && $past(nv_busy)) |-> $stable(wiper_pos));  // R6
endmodule

bind quad_wiper_ctrl qwc_checker #(.WR_DELAY(WR_DELAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_p(stop_p),
  .sda_pull(sda_pull), .nv_busy(nv_busy), .wiper_pos(wiper_pos));

// File: tb/quad_wiper_ctrl_test.sv
`timescale 1ns/1ps
module quad_wiper_ctrl_test;
  localparam int WRD = 400;
  localparam int H   = 8;
  localparam logic [7:0] ID = 8'h56;
  localparam logic [3:0] RD_W = 4'b1001, WR_W = 4'b1010, RD_S = 4'b1011, WR_S = 4'b1100,
                         S2W = 4'b1101, W2S = 4'b1110, GS2W = 4'b0001, GW2S = 4'b1000,
                         STEP = 4'b0010;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic sda_pull, nv_busy;
  logic [31:0] wiper_pos;
  wire sda_line = sda_m & ~sda_pull;

  quad_wiper_ctrl #(.WR_DELAY(WRD)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .dev_addr(4'h6),
    .sda_pull(sda_pull), .nv_busy(nv_busy), .wiper_pos(wiper_pos));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, mon_bad = 0, run = 0, last_run = 0;
  bit chk_on = 0, prev_b = 0, done = 0;
  logic [7:0] exp_w [4];
  logic [7:0] exp_s [16];
  int pk_b = 0;
  logic [3:0] pm_b = 0;
  logic [1:0] ps_b = 0;
  logic [7:0] pd_b = 0;

  always @(negedge clk) if (rst_n) begin
    if (prev_b && !nv_busy) begin
      for (int p = 0; p < 4; p++) if (pm_b[p])
        case (pk_b)
          1: exp_w[p] = exp_s[p*4 + ps_b];
          2: exp_s[p*4 + ps_b] = exp_w[p];
          3: exp_s[p*4 + ps_b] = pd_b;
          default: ;
        endcase
      pk_b = 0;
    end
    if (nv_busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
    prev_b = nv_busy;
    if (chk_on)
      for (int p = 0; p < 4; p++)
        if (wiper_pos[p*8 +: 8] !== exp_w[p]) begin
          mon_bad++;
          $display("[TB] model mismatch wiper %0d: %h vs %h at %0t", p, wiper_pos[p*8 +: 8], exp_w[p], $time);
        end
  end

  task automatic hw(int n); repeat (n) @(negedge clk); endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start; sda_m = 1; hw(H); scl = 1; hw(H); sda_m = 0; hw(H); scl = 0; hw(H); endtask
  task automatic bus_stop;  sda_m = 0; hw(H); scl = 1; hw(H); sda_m = 1; hw(H); endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) begin sda_m = b[i]; hw(H); scl = 1; hw(H); scl = 0; end
    sda_m = 1; hw(H); scl = 1; hw(H/2); a1 = !sda_line; hw(H/2); a2 = !sda_line; scl = 0;
    check(a1 == a2, "R13", "ack level held through SCL high", a2, a1);
    ack = a1;
  endtask

  task automatic get_byte(output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin hw(H); scl = 1; hw(H/2); b[i] = sda_line; hw(H/2); scl = 0; end
    hw(H); scl = 1; hw(H); scl = 0; hw(H);
  endtask

  task automatic cmd2(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p, output bit ok);
    bit a0, a1;
    bus_start; put_byte(ID, a0); put_byte({op, r, p}, a1); bus_stop;
    ok = a0 & a1;
  endtask

  task automatic wr3(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p,
                     input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start; put_byte(ID, a0); put_byte({op, r, p}, a1); put_byte(d, a2); bus_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic rd3(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p,
                     output logic [7:0] d, output bit ok);
    bit a0, a1;
    bus_start; put_byte(ID, a0); put_byte({op, r, p}, a1); get_byte(d); bus_stop;
    ok = a0 & a1;
  endtask

  task automatic settle; while (nv_busy) @(negedge clk); hw(2); endtask

  task automatic wr_wiper(input logic [1:0] p, input logic [7:0] d);
    bit ok;
    chk_on = 0; wr3(WR_W, 2'd0, p, d, ok); exp_w[p] = d; hw(2); chk_on = 1;
    check(ok, "R4", "write wiper acks", ok, 1);
    check(wiper_pos[p*8 +: 8] == d, "R4", "wiper after write", wiper_pos[p*8 +: 8], d);
  endtask

  task automatic wr_store(input logic [1:0] r, input logic [1:0] p, input logic [7:0] d);
    bit ok;
    pk_b = 3; pm_b = 4'(1 << p); ps_b = r; pd_b = d;
    wr3(WR_S, r, p, d, ok); settle;
    check(ok, "R5", "write storage acks", ok, 1);
    check(last_run == WRD, "R5", "busy length", last_run, WRD);
  endtask

  task automatic step_run(input logic [1:0] p, input int ups, input int downs);
    bit a0, a1;
    bus_start; put_byte(ID, a0); put_byte({STEP, 2'd0, p}, a1);
    check(a0 & a1, "R9", "step mode acks", a0 & a1, 1);
    for (int k = 0; k < ups + downs; k++) begin
      chk_on = 0; sda_m = (k < ups); hw(H); scl = 1; hw(H); scl = 0; hw(H);
      if (k < ups) exp_w[p] = (exp_w[p] == 8'hFF) ? 8'hFF : exp_w[p] + 8'd1;
      else         exp_w[p] = (exp_w[p] == 8'h00) ? 8'h00 : exp_w[p] - 8'd1;
      chk_on = 1;
    end
    bus_stop; hw(4);
  endtask

  initial begin
    logic [7:0] d;
    bit ok, a0, a1;
    for (int i = 0; i < 4; i++) exp_w[i] = 0;
    for (int i = 0; i < 16; i++) exp_s[i] = 0;
    hw(5);
    check(wiper_pos == 0, "R12", "reset wipers", wiper_pos, 0);
    check(!nv_busy && !sda_pull, "R12", "reset busy/pull", {nv_busy, sda_pull}, 0);
    rst_n = 1; hw(5); chk_on = 1;

    wr_wiper(2'd1, 8'h5A);
    rd3(RD_W, 2'd0, 2'd1, d, ok);
    check(ok && d == 8'h5A, "R3", "read wiper 1", d, 8'h5A);

    bus_start; put_byte(8'h57, a0); bus_stop;
    check(!a0, "R1", "wrong device address nack", a0, 0);
    bus_start; put_byte(8'h66, a0); put_byte({WR_W, 2'd0, 2'd1}, a1); put_byte(8'h00, a1); bus_stop;
    check(!a0, "R1", "wrong identifier nack", a0, 0);
    check(wiper_pos[15:8] == 8'h5A, "R1", "rejected write has no effect", wiper_pos[15:8], 8'h5A);

    bus_start; put_byte(ID, a0); put_byte(8'h01, a1); bus_stop;
    check(a0 && !a1, "R2", "opcode 0000 nack", a1, 0);
    bus_start; put_byte(ID, a0); put_byte(8'hF1, a1); put_byte(8'h00, a1); bus_stop;
    check(!a1 && !nv_busy && wiper_pos[15:8] == 8'h5A, "R2", "opcode 1111 nack, no change", a1, 0);

    pk_b = 3; pm_b = 4'b0100; ps_b = 2'd3; pd_b = 8'hC3;
    wr3(WR_S, 2'd3, 2'd2, 8'hC3, ok);
    check(ok && nv_busy, "R5", "storage write busy", nv_busy, 1);
    bus_start; put_byte(ID, a0); bus_stop;
    check(nv_busy && !a0, "R11", "identifier refused while busy", a0, 0);
    settle;
    check(last_run == WRD, "R5", "busy length", last_run, WRD);
    rd3(RD_S, 2'd3, 2'd2, d, ok);
    check(ok && d == 8'hC3, "R5", "storage readback", d, 8'hC3);

    pk_b = 1; pm_b = 4'b0100; ps_b = 2'd3;
    cmd2(S2W, 2'd3, 2'd2, ok);
    check(ok && nv_busy && wiper_pos[23:16] == 8'h00, "R6", "wiper held during busy", wiper_pos[23:16], 0);
    settle;
    check(wiper_pos[23:16] == 8'hC3, "R6", "wiper after transfer", wiper_pos[23:16], 8'hC3);

    pk_b = 2; pm_b = 4'b0010; ps_b = 2'd0;
    cmd2(W2S, 2'd0, 2'd1, ok); settle;
    rd3(RD_S, 2'd0, 2'd1, d, ok);
    check(ok && d == 8'h5A, "R7", "wiper copied to storage", d, 8'h5A);

    wr_store(2'd2, 2'd0, 8'h11); wr_store(2'd2, 2'd1, 8'h22);
    wr_store(2'd2, 2'd2, 8'h33); wr_store(2'd2, 2'd3, 8'h44);
    pk_b = 1; pm_b = 4'hF; ps_b = 2'd2;
    cmd2(GS2W, 2'd2, 2'd1, ok); settle;
    check(ok && wiper_pos == 32'h44332211, "R8", "ganged storage to wiper", wiper_pos, 32'h44332211);
    wr_wiper(2'd2, 8'h77);
    pk_b = 2; pm_b = 4'hF; ps_b = 2'd1;
    cmd2(GW2S, 2'd1, 2'd3, ok); settle;
    rd3(RD_S, 2'd1, 2'd2, d, ok);
    check(ok && d == 8'h77, "R8", "ganged copy channel 2", d, 8'h77);
    rd3(RD_S, 2'd1, 2'd0, d, ok);
    check(ok && d == 8'h11, "R8", "ganged copy channel 0", d, 8'h11);

    step_run(2'd0, 3, 1);
    check(wiper_pos[7:0] == 8'h13, "R9", "three up one down, no STOP step", wiper_pos[7:0], 8'h13);

    wr_wiper(2'd3, 8'hFE);
    step_run(2'd3, 3, 0);
    check(wiper_pos[31:24] == 8'hFF, "R10", "saturate high", wiper_pos[31:24], 8'hFF);
    wr_wiper(2'd3, 8'h01);
    step_run(2'd3, 0, 3);
    check(wiper_pos[31:24] == 8'h00, "R10", "saturate low", wiper_pos[31:24], 8'h00);

    bus_start; put_byte(ID, a0); put_byte({WR_W, 2'd0, 2'd0}, a1);
    for (int i = 0; i < 4; i++) begin sda_m = 1'b0; hw(H); scl = 1; hw(H); scl = 0; end
    bus_start; bus_stop; hw(4);
    check(wiper_pos[7:0] == 8'h13, "R12", "START aborts write", wiper_pos[7:0], 8'h13);
    check(!sda_pull, "R12", "SDA released after STOP", sda_pull, 0);

    check(mon_bad == 0, "R4/R6", "per-cycle model compare", mon_bad, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule